// File: doc/BRIEF.md
# PLL Dynamic Phase-Step Sequencer

This controller lives in user logic and runs on the same scan clock as a PLL's dynamic phase-adjust port. A host hands it one command: how many phase steps to take, which way to move, and a code that selects the PLL output counter to adjust. The sequencer then runs a burst of handshakes. For each step it raises a request and holds it for at least two cycles. It waits until the PLL's acknowledge line, seen through a two-flop synchronizer, goes low, and only then drops the request. It then waits for the acknowledge line to return high before it starts the next step.

The PLL samples the request on the falling clock edge. It takes the direction and select values on the second rising edge after that sample. For this reason the sequencer drives every output from a register on the rising edge, and it keeps direction and select constant for the whole burst. The PLL may keep the acknowledge low for a short or a long time, so no fixed duration is assumed. Two watchdogs guard the handshake. The first fires when the acknowledge does not fall within eight cycles of the request. The second fires when the acknowledge does not come back within a limit that the host sets. Either one aborts the burst and sets an error flag, which stays set until the next command.

Top module: `phase_step_seq`

## Requirements
- R1: After reset, `pll_step`, `busy`, `done_pulse` and `err` are low and `cmd_ready` is high.
- R2: A command is accepted only when `cmd_ready` is high. A `cmd_valid` during a burst has no effect on the step count, on direction or select, or on the number of completions.
- R3: `pll_dir` and `pll_sel` take the command's values at acceptance and do not change while `busy` is high.
- R4: Each request pulse stays high for at least two cycles, and it is dropped only after the acknowledge line has gone low.
- R5: A new request starts only after the acknowledge line has returned high, and only after at least one cycle with the request low.
- R6: A command with count N>0 produces exactly N phase steps. It then gives one single-cycle `done_pulse`, and `busy` falls.
- R7: A count of zero issues no request. It gives `done_pulse` high for one cycle, in the cycle after acceptance.
- R8: If the acknowledge does not fall while the request has been high for 8 cycles, the request drops, `err` rises, no `done_pulse` is given, and the block returns to idle.
- R9: If the acknowledge does not rise within `rise_limit` cycles after a request is dropped, the burst is aborted with `err` high and no `done_pulse`.
- R10: `err` stays high until the next accepted command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all logic on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_steps | input | CNT_W | Number of phase steps |
| cmd_dir | input | 1 | Step direction (1 = up) |
| cmd_sel | input | SEL_W | Counter-select code |
| rise_limit | input | LIM_W | Cycles allowed for the acknowledge to return high |
| cmd_ready | output | 1 | Idle, a command is accepted |
| busy | output | 1 | Burst in progress |
| done_pulse | output | 1 | One-cycle completion strobe |
| err | output | 1 | Sticky timeout flag |
| pll_done | input | 1 | Asynchronous acknowledge from the PLL |
| pll_step | output | 1 | Phase-step request |
| pll_dir | output | 1 | Direction to the PLL |
| pll_sel | output | SEL_W | Counter select to the PLL |

## Verification
Random bursts use counts from 0 to 5, random direction and select, and acknowledge-low times from one to six cycles. These runs show whether the step count, the values captured per step and the request pulse shapes stay correct for both short and long acknowledge pulses. Separate directed cases cover a zero count, a PLL that never acknowledges, a PLL that never finishes, and a second command sent in the middle of a burst. They tell the completion path apart from each abort path, and they show whether commands are gated while the block is busy.

// File: rtl/ps_pkg.sv
package ps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ps_state_t;
endpackage

// File: rtl/ps_done_sync.sv
module ps_done_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ps_timer.sv
module ps_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)        count <= '0;
    else if (count != MAXV) count <= count + 1'b1;
  end
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq
  import ps_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 3,
  parameter int LIM_W       = 8,
  parameter int FALL_LIM    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] cmd_steps,
  input  logic             cmd_dir,
  input  logic [SEL_W-1:0] cmd_sel,
  input  logic [LIM_W-1:0] rise_limit,
  output logic             cmd_ready,
  output logic             busy,
  output logic             done_pulse,
  output logic             err,
  input  logic             pll_done,
  output logic             pll_step,
  output logic             pll_dir,
  output logic [SEL_W-1:0] pll_sel
);
  localparam int FALL_W = $clog2(FALL_LIM + 1);
  localparam int TMR_W  = (LIM_W > FALL_W) ? LIM_W : FALL_W;
  localparam logic [TMR_W-1:0] FALL_LAST = TMR_W'(FALL_LIM - 1);

  ps_state_t        state, state_n;
  logic [CNT_W-1:0] remain;
  logic [TMR_W-1:0] tcnt;
  logic             done_s;
  logic             accept, fin, abort, dec;

  ps_done_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pll_done), .sync_out(done_s)
  );

  ps_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .clr(state_n != state), .count(tcnt)
  );

  assign accept = cmd_valid && (state == ST_IDLE);

  always_comb begin
    state_n = state;
    fin     = 1'b0;
    abort   = 1'b0;
    dec     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (cmd_steps == '0) fin = 1'b1;
          else                 state_n = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!done_s && tcnt >= TMR_W'(1)) begin
          state_n = ST_WAIT;
          dec     = 1'b1;
        end else if (tcnt >= FALL_LAST) begin
          state_n = ST_IDLE;
          abort   = 1'b1;
        end
      end
      ST_WAIT: begin
        if (done_s) begin
          if (remain == '0) begin
            state_n = ST_IDLE;
            fin     = 1'b1;
          end else begin
            state_n = ST_REQ;
          end
        end else if (tcnt >= TMR_W'(rise_limit)) begin
          state_n = ST_IDLE;
          abort   = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      remain     <= '0;
      pll_dir    <= 1'b0;
      pll_sel    <= '0;
      pll_step   <= 1'b0;
      done_pulse <= 1'b0;
      err        <= 1'b0;
      busy       <= 1'b0;
      cmd_ready  <= 1'b1;
    end else begin
      state      <= state_n;
      pll_step   <= (state_n == ST_REQ);
      done_pulse <= fin;
      busy       <= (state_n != ST_IDLE);
      cmd_ready  <= (state_n == ST_IDLE);
      if (accept) begin
        remain  <= cmd_steps;
        pll_dir <= cmd_dir;
        pll_sel <= cmd_sel;
      end else if (dec) begin
        remain  <= remain - 1'b1;
      end
      if (accept)     err <= 1'b0;
      else if (abort) err <= 1'b1;
    end
  end
endmodule

// File: rtl/phase_step_seq_chk.sv
module phase_step_seq_chk #(
  parameter int SEL_W    = 3,
  parameter int FALL_LIM = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done_pulse,
  input logic             pll_done,
  input logic             pll_step,
  input logic             pll_dir,
  input logic [SEL_W-1:0] pll_sel
);
  localparam int RW = $clog2(FALL_LIM + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)           run <= '0;
    else if (pll_step) run <= run + 1'b1;
    else               run <= '0;
  end

  assert_min_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_step) |-> $past(pll_step, 2));

  assert_run_limit_R8: assert property (@(posedge clk) disable iff (rst)
    pll_step |-> (run < RW'(FALL_LIM)));

  assert_stable_cfg_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(pll_dir) && $stable(pll_sel)));

  assert_one_cycle_done_R6: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  assert_no_step_at_done_R7: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> !pll_step);

  assert_ack_high_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_step) |-> $past(pll_done));
endmodule

bind phase_step_seq phase_step_seq_chk #(.SEL_W(SEL_W), .FALL_LIM(FALL_LIM)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done_pulse(done_pulse),
  .pll_done(pll_done), .pll_step(pll_step), .pll_dir(pll_dir), .pll_sel(pll_sel)
);

// File: tb/tb_phase_step_seq.sv
module pll_phase_model #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             dir,
  input  logic [SEL_W-1:0] sel,
  input  logic             no_fall,
  input  logic             no_rise,
  input  logic [3:0]       low_len,
  output logic             done,
  output logic             cap_pulse,
  output logic             cap_dir,
  output logic [SEL_W-1:0] cap_sel
);
  logic       s_neg;
  logic [7:0] req_tok, ack_tok;
  logic       edge_cnt;
  logic [3:0] low_cnt;

  always_ff @(negedge clk) begin
    if (rst) begin
      s_neg   <= 1'b0;
      req_tok <= '0;
    end else begin
      s_neg <= step;
      if (step && !s_neg) req_tok <= req_tok + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_tok   <= '0;
      edge_cnt  <= 1'b0;
      done      <= 1'b1;
      low_cnt   <= '0;
      cap_pulse <= 1'b0;
      cap_dir   <= 1'b0;
      cap_sel   <= '0;
    end else begin
      cap_pulse <= 1'b0;
      if (req_tok != ack_tok) begin
        if (edge_cnt) begin
          edge_cnt <= 1'b0;
          ack_tok  <= req_tok;
          if (!no_fall) begin
            cap_pulse <= 1'b1;
            cap_dir   <= dir;
            cap_sel   <= sel;
            done      <= 1'b0;
            low_cnt   <= '0;
          end
        end else begin
          edge_cnt <= 1'b1;
        end
      end else if (!done) begin
        if (!no_rise && low_cnt + 4'd1 >= low_len) done <= 1'b1;
        else                                       low_cnt <= low_cnt + 1'b1;
      end
    end
  end
endmodule

module tb_phase_step_seq;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;
  localparam int LIM_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             cmd_valid;
  logic [CNT_W-1:0] cmd_steps;
  logic             cmd_dir;
  logic [SEL_W-1:0] cmd_sel;
  logic [LIM_W-1:0] rise_limit;
  logic             cmd_ready, busy, done_pulse, err;
  logic             pll_done, pll_step, pll_dir;
  logic [SEL_W-1:0] pll_sel;
  logic             no_fall, no_rise;
  logic [3:0]       low_len;
  logic             cap_pulse, cap_dir;
  logic [SEL_W-1:0] cap_sel;

  int errors = 0;
  int checks = 0;
  int shifts = 0;
  int mism = 0;
  int dones = 0;
  int viol = 0;
  int run_hi = 0;
  logic seen_low = 1'b0;
  logic prev_step = 1'b0;
  logic             exp_dir;
  logic [SEL_W-1:0] exp_sel;

  always #5 clk = ~clk;

  phase_step_seq #(.CNT_W(CNT_W), .SEL_W(SEL_W), .LIM_W(LIM_W)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_steps(cmd_steps),
    .cmd_dir(cmd_dir), .cmd_sel(cmd_sel), .rise_limit(rise_limit),
    .cmd_ready(cmd_ready), .busy(busy), .done_pulse(done_pulse), .err(err),
    .pll_done(pll_done), .pll_step(pll_step), .pll_dir(pll_dir), .pll_sel(pll_sel)
  );

  pll_phase_model #(.SEL_W(SEL_W)) u_pll (
    .clk(clk), .rst(rst), .step(pll_step), .dir(pll_dir), .sel(pll_sel),
    .no_fall(no_fall), .no_rise(no_rise), .low_len(low_len), .done(pll_done),
    .cap_pulse(cap_pulse), .cap_dir(cap_dir), .cap_sel(cap_sel)
  );

  // Protocol monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (cap_pulse) begin
        shifts++;
        if (cap_dir !== exp_dir || cap_sel !== exp_sel) mism++;
      end
      if (done_pulse) dones++;
      if (pll_step) begin
        if (!prev_step && !pll_done) viol++;      // R5: start only with ack high
        run_hi++;
        if (!pll_done) seen_low = 1'b1;
      end else if (prev_step) begin
        if (run_hi < 2) viol++;                   // R4: hold two cycles
        if (!seen_low && !err) viol++;            // R4: drop only after ack low
        run_hi = 0;
        seen_low = 1'b0;
      end
      prev_step = pll_step;
    end
  end

  function automatic void check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  task automatic issue(input int n, input bit d, input int s);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_steps = CNT_W'(n); cmd_dir = d; cmd_sel = SEL_W'(s);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic burst(input int n, input bit d, input int s, input int ll, input string req);
    int s0, d0, m0, v0;
    low_len = 4'(ll);
    exp_dir = d; exp_sel = SEL_W'(s);
    s0 = shifts; d0 = dones; m0 = mism; v0 = viol;
    issue(n, d, s);
    wait_idle();
    check(shifts - s0 == n, {req, " R6 step count"}, shifts - s0, n);
    check(dones - d0 == 1, {req, " R6 one completion"}, dones - d0, 1);
    check(mism == m0, {req, " R3 captured dir/sel"}, mism - m0, 0);
    check(viol == v0, {req, " R4/R5 handshake shape"}, viol - v0, 0);
    check(err == 1'b0, {req, " R10 err clear"}, err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0, d0;
    void'($urandom(32'd2024));
    rst = 1'b1; cmd_valid = 1'b0; cmd_steps = '0; cmd_dir = 1'b0; cmd_sel = '0;
    rise_limit = 8'd20; no_fall = 1'b0; no_rise = 1'b0; low_len = 4'd2;
    exp_dir = 1'b0; exp_sel = '0;
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pll_step == 1'b0 && busy == 1'b0 && done_pulse == 1'b0 && err == 1'b0,
          "R1 reset outputs low", {busy, pll_step, done_pulse, err}, 0);
    check(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);

    // R7 zero count: done_pulse in the cycle after acceptance, no request
    s0 = shifts;
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_steps = '0;
    @(negedge clk);
    check(done_pulse == 1'b0, "R7 no pulse before accept", done_pulse, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(done_pulse == 1'b1 && pll_step == 1'b0, "R7 pulse after accept", done_pulse, 1);
    @(negedge clk);
    check(done_pulse == 1'b0, "R7 pulse one cycle", done_pulse, 0);
    check(shifts == s0, "R7 no step", shifts - s0, 0);

    // Directed bursts: single step with short and long acknowledge
    burst(1, 1'b1, 5, 1, "dir short-ack");
    burst(3, 1'b0, 2, 6, "dir long-ack");

    // Random bursts
    for (int k = 0; k < 20; k++) begin
      burst(int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
            int'($urandom_range(0, 7)), int'($urandom_range(1, 6)), "rand");
    end

    // R2: command during burst ignored
    low_len = 4'd4; exp_dir = 1'b0; exp_sel = 3'd1;
    s0 = shifts; d0 = dones;
    issue(3, 1'b0, 1);
    repeat (4) @(posedge clk);
    #1; cmd_valid = 1'b1; cmd_steps = 8'd2; cmd_dir = 1'b1; cmd_sel = 3'd5;
    @(negedge clk);
    check(pll_dir == 1'b0 && pll_sel == 3'd1, "R2 dir/sel unchanged mid-burst", pll_sel, 1);
    @(posedge clk); #1; cmd_valid = 1'b0;
    wait_idle();
    check(shifts - s0 == 3, "R2 step count unaffected", shifts - s0, 3);
    check(dones - d0 == 1, "R2 single completion", dones - d0, 1);

    // R8: acknowledge never falls
    no_fall = 1'b1; s0 = shifts; d0 = dones;
    issue(2, 1'b1, 3);
    wait_idle();
    check(err == 1'b1, "R8 err on fall timeout", err, 1);
    check(pll_step == 1'b0 && cmd_ready == 1'b1, "R8 back to idle", pll_step, 0);
    check(dones == d0, "R8 no completion", dones - d0, 0);
    no_fall = 1'b0;
    repeat (5) @(negedge clk);
    check(err == 1'b1, "R10 err held", err, 1);

    // R10: next command clears err; R9: acknowledge never returns
    no_rise = 1'b1; rise_limit = 8'd4; low_len = 4'd2;
    exp_dir = 1'b1; exp_sel = 3'd6; s0 = shifts; d0 = dones;
    issue(3, 1'b1, 6);
    @(negedge clk);
    check(err == 1'b0, "R10 err cleared on accept", err, 0);
    wait_idle();
    check(err == 1'b1, "R9 err on rise timeout", err, 1);
    check(shifts - s0 == 1, "R9 stopped after first step", shifts - s0, 1);
    check(dones == d0, "R9 no completion", dones - d0, 0);

    // Recover: PLL returns high after reset of the model's behavior
    no_rise = 1'b0; rise_limit = 8'd20;
    rst = 1'b1; repeat (3) @(posedge clk); #1; rst = 1'b0;
    burst(2, 1'b0, 7, 3, "after abort");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule